// File: doc/BRIEF.md
# Register Read Port Arbiter

This block lets several functional-unit operand slots share a single register-file read port. Each slot presents a read request, a select line that says its unit owns the current issue, a per-operand read flag and a register number. A fixed-priority picker grants at most one eligible slot per cycle. The granted slot's register number is placed on the port address in the same cycle, and the port read enable is raised.

The register file answers one cycle later. At that point a registered copy of the grant does two jobs. It pulses the go-read strobe to the winning slot. It also steers the shared read-data bus into that slot's operand register. A slot whose registered grant is high is kept out of the picker for that cycle, so it cannot be granted twice in a row.

A build-time variant drives a one-hot enable vector instead of a binary address. That vector is the OR of each slot's decoded, grant-gated register number.

Top module: `reg_rd_arb`

## Requirements
- R1: A slot takes part in arbitration only when its request, select and read flag are all high. If any of the three is low, that slot gets no read enable and no go-read.
- R2: When more than one slot is eligible, the lowest-numbered slot is granted. At most one slot is granted per cycle, and slot i's go-read is bit i of `go_rd_o`.
- R3: In the cycle of a grant, `port_addr_o` equals the winner's register number and `port_ren_o` is high. With no grant, `port_ren_o` is low and the address is zero.
- R4: Go-read to a slot is high for exactly the one cycle after the cycle in which it was granted.
- R5: A slot whose go-read is high cannot be granted in that cycle. A slot that keeps its request high is therefore granted every other cycle.
- R6: In a go-read cycle, `port_data_i` is stored into that slot's operand register. The stored value is visible from the next cycle. All slots share `port_data_i`.
- R7: An operand register keeps its value in every cycle where its slot's go-read is low.
- R8: With `UNARY=1`, `port_onehot_o` has only bit `reg_num` of the granted slot set. In that mode `port_addr_o` stays zero and `port_ren_o` is high on a grant.
- R9: While `rst_ni` is low, all go-read strobes, the read enable and every operand register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | NUM_REQ | Read request per slot |
| unit_sel_i | input | NUM_REQ | Owning unit selected for the current issue |
| rd_flag_i | input | NUM_REQ | Per-operand read flag |
| reg_num_i | input | NUM_REQ*ADDR_W | Register number per slot, slot i at bits [i*ADDR_W +: ADDR_W] |
| port_addr_o | output | ADDR_W | Binary read address (zero in unary mode) |
| port_ren_o | output | 1 | Read enable to the register file |
| port_onehot_o | output | 2**ADDR_W | One-hot read enable vector (zero in binary mode) |
| port_data_i | input | DATA_W | Read data, returned one cycle after the address |
| go_rd_o | output | NUM_REQ | Go-read strobe per slot |
| operand_o | output | NUM_REQ*DATA_W | Captured operand per slot, slot i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest case to reach is a slot that keeps its request high through its own go-read cycle. Only then does the mask decide whether a lower-priority slot gets the port or the same slot is granted twice. The stimulus drops each slot's request only after its go-read is seen, with several slots starting in the same cycle, so grants interleave with masking. It also holds one request high for many cycles to observe the alternating grant pattern. A scoreboard predicts the grant order and the value each operand register must capture from a register-file model inside the bench.

// File: rtl/reg_rd_arb_pkg.sv
package reg_rd_arb_pkg;
  function automatic int unsigned num_regs(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any_o = found;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  low_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/or_merge.sv
module or_merge #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0][W-1:0] in_i,
  output logic [W-1:0]        out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < int'(N); i++) out_o |= in_i[i];
  end
endmodule

// File: rtl/rd_lane.sv
module rd_lane #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  parameter bit          UNARY  = 1'b0,
  parameter int unsigned NREG   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              sel_i,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] num_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pick_o,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NREG-1:0]   onehot_o,
  output logic [DATA_W-1:0] operand_o
);
  logic dly_q;

  // delayed grant masks the slot out of the picker
  assign pick_o = req_i & sel_i & flag_i & ~dly_q;
  assign go_o   = dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= gnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    operand_o <= '0;
    else if (dly_q) operand_o <= data_i;
  end

  generate
    if (UNARY) begin : g_unary
      assign addr_o   = '0;
      assign onehot_o = gnt_i ? (NREG'(1) << num_i) : '0;
    end else begin : g_binary
      assign addr_o   = gnt_i ? num_i : '0;
      assign onehot_o = '0;
    end
  endgenerate

  // R5
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !gnt_i);

  // R4
  go_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> go_o);

  // R6
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> (operand_o == $past(data_i)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_o |=> $stable(operand_o));
endmodule

// File: rtl/reg_rd_arb.sv
module reg_rd_arb #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter bit          UNARY   = 1'b0,
  localparam int unsigned NREG   = reg_rd_arb_pkg::num_regs(ADDR_W)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_REQ-1:0]          rd_req_i,
  input  logic [NUM_REQ-1:0]          unit_sel_i,
  input  logic [NUM_REQ-1:0]          rd_flag_i,
  input  logic [NUM_REQ*ADDR_W-1:0]   reg_num_i,
  output logic [ADDR_W-1:0]           port_addr_o,
  output logic                        port_ren_o,
  output logic [NREG-1:0]             port_onehot_o,
  input  logic [DATA_W-1:0]           port_data_i,
  output logic [NUM_REQ-1:0]          go_rd_o,
  output logic [NUM_REQ*DATA_W-1:0]   operand_o
);
  logic [NUM_REQ-1:0]             pick;
  logic [NUM_REQ-1:0]             gnt;
  logic                           any_gnt;
  logic [NUM_REQ-1:0][ADDR_W-1:0] addr_arr;
  logic [NUM_REQ-1:0][NREG-1:0]   oh_arr;

  prio_pick #(.N(NUM_REQ)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (pick),
    .gnt_o (gnt),
    .any_o (any_gnt)
  );

  for (genvar i = 0; i < int'(NUM_REQ); i++) begin : g_lane
    rd_lane #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNARY(UNARY), .NREG(NREG)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (rd_req_i[i]),
      .sel_i    (unit_sel_i[i]),
      .flag_i   (rd_flag_i[i]),
      .num_i    (reg_num_i[i*ADDR_W +: ADDR_W]),
      .gnt_i    (gnt[i]),
      .data_i   (port_data_i),
      .pick_o   (pick[i]),
      .go_o     (go_rd_o[i]),
      .addr_o   (addr_arr[i]),
      .onehot_o (oh_arr[i]),
      .operand_o(operand_o[i*DATA_W +: DATA_W])
    );
  end

  or_merge #(.N(NUM_REQ), .W(ADDR_W)) u_addr_or (
    .in_i (addr_arr),
    .out_o(port_addr_o)
  );

  or_merge #(.N(NUM_REQ), .W(NREG)) u_oh_or (
    .in_i (oh_arr),
    .out_o(port_onehot_o)
  );

  assign port_ren_o = any_gnt;

  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_req_i & unit_sel_i & rd_flag_i) == '0) |-> !port_ren_o);

  // R4
  go_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_rd_o));

  // R8
  oh_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (UNARY && port_ren_o) |-> ($countones(port_onehot_o) == 1));
endmodule

// File: tb/reg_rd_arb_test.sv
`timescale 1ns/1ps
module reg_rd_arb_test;
  localparam int N  = 4;
  localparam int AW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, sel = '0, flag = '0;
  logic [N*AW-1:0] nums = '0;
  logic [AW-1:0] addr, addr_oh;
  logic          ren, ren_oh;
  logic [31:0]   oh, oh_oh;
  logic [DW-1:0] rdata = '0;
  logic [N-1:0]  go, go_oh;
  logic [N*DW-1:0] opnd, opnd_oh;

  always #2.5 clk = ~clk;

  reg_rd_arb #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW), .UNARY(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req), .unit_sel_i(sel),
    .rd_flag_i(flag), .reg_num_i(nums), .port_addr_o(addr), .port_ren_o(ren),
    .port_onehot_o(oh), .port_data_i(rdata), .go_rd_o(go), .operand_o(opnd));

  reg_rd_arb #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW), .UNARY(1'b1)) uut_oh (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req), .unit_sel_i(sel),
    .rd_flag_i(flag), .reg_num_i(nums), .port_addr_o(addr_oh), .port_ren_o(ren_oh),
    .port_onehot_o(oh_oh), .port_data_i(rdata), .go_rd_o(go_oh), .operand_o(opnd_oh));

  function automatic logic [DW-1:0] rf_val(input logic [AW-1:0] r);
    return 16'h1000 + 16'(r) * 16'h0111;
  endfunction

  // register file model: synchronous read
  always @(posedge clk) if (ren) rdata <= rf_val(addr);

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] op_of(input int i);
    return opnd[i*DW +: DW];
  endfunction

  typedef struct { int idx; logic [DW-1:0] data; } item_t;
  item_t q[$];
  logic [DW-1:0] last [N];
  bit sb_on = 1'b0;
  bit chk_pend = 1'b0;
  int chk_idx;
  logic [DW-1:0] chk_data;

  // monitor: grant order (R2, R4) and capture (R6)
  always @(negedge clk) begin
    if (sb_on) begin
      if (chk_pend) begin
        chk(op_of(chk_idx) == chk_data, "R6 operand capture", 64'(op_of(chk_idx)), 64'(chk_data));
        chk_pend = 1'b0;
      end
      if (go != '0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4 unexpected go-read", 64'(go), 64'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(go == (N'(1) << it.idx), "R2 grant order", 64'(go), 64'(N'(1) << it.idx));
          chk_idx = it.idx;
          chk_data = it.data;
          chk_pend = 1'b1;
          last[it.idx] = it.data;
        end
      end
    end
  end

  // driver: start requests on slots in m, drop each one after its go-read
  task automatic run_batch(input logic [N-1:0] m, input logic [N*AW-1:0] rn);
    int low;
    low = -1;
    @(negedge clk);
    nums = rn; sel = m; flag = m; req = m;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        item_t it;
        it.idx = i;
        it.data = rf_val(rn[i*AW +: AW]);
        q.push_back(it);
        if (low < 0) low = i;
      end
    end
    #1;
    // R3 address of lowest eligible slot, R8 unary twin
    chk(ren && addr == rn[low*AW +: AW], "R3 port address", {ren, 32'(addr)}, {1'b1, 32'(rn[low*AW +: AW])});
    chk(ren_oh && addr_oh == '0 && oh_oh == (32'd1 << rn[low*AW +: AW]), "R8 one-hot enable",
        64'(oh_oh), 64'(32'd1 << rn[low*AW +: AW]));
    for (int k = 0; k < 40 && req != '0; k++) begin
      @(negedge clk);
      req = req & ~go;
    end
    sel = '0; flag = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) last[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(go == '0 && ren == 1'b0, "R9 reset strobes", {ren, 60'(go)}, 64'd0);
    chk(opnd == '0, "R9 reset operands", 64'(opnd), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ren == 1'b0 && addr == '0, "R3 idle port", {ren, 32'(addr)}, 64'd0);

    // R1 select low: ignored
    req = '1; flag = '1; sel = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ren == 1'b0 && go == '0, "R1 select low ignored", {ren, 60'(go)}, 64'd0);
    end
    // R1 read flag low: ignored
    sel = '1; flag = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ren == 1'b0 && go == '0, "R1 flag low ignored", {ren, 60'(go)}, 64'd0);
    end
    req = '0; sel = '0;
    chk(opnd == '0, "R1 operands untouched", 64'(opnd), 64'd0);

    sb_on = 1'b1;
    run_batch(4'b0100, {5'd0, 5'd7, 5'd0, 5'd0});
    run_batch(4'b1010, {5'd30, 5'd0, 5'd12, 5'd0});
    run_batch(4'b1111, {5'd3, 5'd17, 5'd31, 5'd1});
    run_batch(4'b0001, {5'd0, 5'd0, 5'd0, 5'd22});
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all grants seen", 64'(q.size()), 64'd0);
    sb_on = 1'b0;

    // R5 held request alternates grants
    @(negedge clk);
    nums = {5'd0, 5'd0, 5'd0, 5'd9}; req = 4'b0001; sel = 4'b0001; flag = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(go[0] == ((k % 2) == 0), "R5 back-to-back mask", 64'(go[0]), 64'((k % 2) == 0));
    end
    req = '0; sel = '0; flag = '0;
    last[0] = rf_val(5'd9);
    repeat (2) @(negedge clk);
    chk(op_of(0) == rf_val(5'd9), "R6 capture after held request", 64'(op_of(0)), 64'(rf_val(5'd9)));

    // R7 operands hold through idle and other traffic
    repeat (5) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(op_of(i) == last[i], "R7 operand hold", 64'(op_of(i)), 64'(last[i]));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule